// File: doc/BRIEF.md
# Serial Flash Read-Path Interface

This block is the device side of the four-wire serial link of a 128K x 8 flash. The chip-select, serial clock, serial data-in and hold pins are oversampled with the fast system clock through two-flop synchronizers. Every edge is detected in the system-clock domain, so the system clock must run at least four times faster than the serial clock. The block collects the opcode and address bytes, most significant bit first, on serial-clock rising edges. For the commands that only return data it shifts the answer out on falling edges and raises an output enable while it drives.

There are four answer sources. Array bytes are fetched from an external memory model through a one-cycle byte-read port, for the plain read and for the fast read with one dummy byte. The status byte comes from a companion block. Two fixed identification bytes alternate without end. The read address is 17 bits wide and wraps at the top of the array.

On every chip-select release the block hands the command/protection controller one summary of the transfer. The summary holds the opcode, the 17-bit address, whether the transfer ended on a byte boundary, and how many whole bytes were received.

Top module: `sflash_spi_front`

## Requirements
- R1: The clock polarity is taken from the serial-clock level when chip select falls. Low selects mode 0 and high selects mode 3. In mode 3 the falling edge that comes before the first rising edge shifts nothing, and both modes return identical data.
- R2: Input bits are taken on serial-clock rising edges, most significant bit first. `so` changes only in the system cycle after a detected serial-clock falling edge, and every output byte starts with its bit 7.
- R3: `so_oe` is 0 after reset, while chip select is high, during every input byte (opcode, address, dummy) and while hold is active. It is 1 only while read, status or identification data is being returned.
- R4: Opcode 03h is followed by three address bytes. Bit 7 of the first data byte is driven on the falling edge that ends the last address byte, and further bytes follow at consecutive addresses.
- R5: Only bit 0 of the first address byte is used, as address bit 16; the rest of that byte is ignored. The read address steps by one per byte and wraps from 1FFFFh to 00000h. `mem_rd_en` is a one-cycle pulse with `mem_rd_addr`, and it never pulses while chip select stays high.
- R6: Opcode 0Bh is followed by three address bytes and one ignored byte. Data starts on the falling edge that ends that ignored byte.
- R7: Opcode 05h returns `status_byte`, sampled when each output byte begins. It repeats for as long as the clock runs.
- R8: Opcode 9Fh returns 62h, then 1Dh, and keeps alternating.
- R9: Opcode ABh is followed by two ignored bytes and one address byte. Output then alternates between 62h and 1Dh. It starts with 62h when bit 0 of the address byte is 0 and with 1Dh when it is 1.
- R10: Hold is entered on a falling edge of `hold_n_pin` only while the serial clock is low. It is left on the rising edge. While hold is active, serial-clock and data-in activity has no effect and `so_oe` is 0. A chip-select rise also clears hold.
- R11: On each chip-select rise `cmd_done` pulses for one cycle, with these report fields:
  - `cmd_opcode`: the first byte, or 00h if no whole byte arrived.
  - `cmd_addr`: the assembled 17-bit address, or 0 when no address byte arrived.
  - `cmd_bytes`: the count of whole bytes.
  - `cmd_aligned`: 1 only if at least one byte arrived and no partial byte followed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select, active low, asynchronous |
| sck_pin | input | 1 | Serial clock, asynchronous |
| si_pin | input | 1 | Serial data in, asynchronous |
| hold_n_pin | input | 1 | Hold, active low, asynchronous |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| mem_rd_en | output | 1 | One-cycle array read strobe |
| mem_rd_addr | output | ADDR_W | Array byte address, valid with `mem_rd_en` |
| mem_rd_data | input | 8 | Array byte, valid from the cycle after the strobe until the next strobe |
| status_byte | input | 8 | Current status byte from the companion block |
| cmd_done | output | 1 | One-cycle pulse on chip-select release |
| cmd_opcode | output | 8 | Opcode of the finished transfer |
| cmd_addr | output | ADDR_W | Address of the finished transfer |
| cmd_aligned | output | 1 | Transfer ended on a byte boundary |
| cmd_bytes | output | CNT_W | Whole bytes received, saturating |

## Verification
The bench goes after several corner cases:
- **Address wrap.** A read starts near 1FFFFh with the ignored address bits set. A design that kept the upper bits, or did not wrap, would return bytes from the wrong addresses.
- **Hold.** Hold is applied in the middle of a read while the serial clock and data toggle. A design that did not freeze would skip output bits, and one that kept driving would show `so_oe` high.
- **Mode 3.** Reads in mode 3 catch a design that shifts on the leading falling edge, which moves every byte by one bit.
- **Read timing.** The first data bit of plain and fast reads catches an off-by-one-byte start.
- **Identification order.** Both opcodes, and both values of bit 0 for ABh, expose a wrong byte order.
- **Completion report.** A partial last byte and an empty selection probe the alignment flag and the byte count.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_JID   = 8'h9F;
  localparam logic [7:0] OP_RID   = 8'hAB;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MEM,
    SRC_STAT,
    SRC_ID
  } src_e;
endpackage

// File: rtl/sfi_sync.sv
module sfi_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfi_events.sv
module sfi_events (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_s,
  output logic active,
  output logic cs_fall,
  output logic cs_rise,
  output logic rise_ev,
  output logic fall_ev,
  output logic held
);
  logic cs_p, sck_p, hold_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p   <= 1'b1;
      sck_p  <= 1'b0;
      hold_p <= 1'b1;
    end else begin
      cs_p   <= cs_s;
      sck_p  <= sck_s;
      hold_p <= hold_s;
    end
  end

  assign active  = !cs_s;
  assign cs_fall = cs_p && !cs_s;
  assign cs_rise = !cs_p && cs_s;
  assign rise_ev = active && !held && !cs_fall && sck_s && !sck_p;
  assign fall_ev = active && !held && !cs_fall && !sck_s && sck_p;

  always_ff @(posedge clk) begin
    if (rst || !active) held <= 1'b0;
    else if (hold_p && !hold_s && !sck_s) held <= 1'b1;
    else if (!hold_p && hold_s) held <= 1'b0;
  end

  // R10: hold may only begin while the serial clock sits low
  p_hold_entry_sck_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> $past(!sck_s));
endmodule

// File: rtl/sfi_tx.sv
module sfi_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          start,
  input  logic          fall_ev,
  input  logic [DW-1:0] load,
  output logic          so,
  output logic          act,
  output logic          byte_end
);
  localparam int CW = $clog2(DW);

  logic          pend;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      so <= 1'b0; act <= 1'b0; pend <= 1'b0;
      sh <= '0; cnt <= '0; byte_end <= 1'b0;
    end else begin
      byte_end <= 1'b0;
      if (clear) begin
        act <= 1'b0; pend <= 1'b0; cnt <= '0;
      end else begin
        if (start) pend <= 1'b1;
        if (fall_ev && (act || pend)) begin
          act  <= 1'b1;
          pend <= 1'b0;
          if (cnt == '0) begin
            so <= load[DW-1];
            sh <= {load[DW-2:0], 1'b0};
          end else begin
            so <= sh[DW-1];
            sh <= {sh[DW-2:0], 1'b0};
          end
          cnt      <= cnt + 1'b1;
          byte_end <= (cnt == CW'(DW-1));
        end
      end
    end
  end

  // R2: the output bit only moves after a detected falling edge
  p_so_on_fall_only_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(fall_ev) |-> $stable(so));
endmodule

// File: rtl/sflash_spi_front.sv
module sflash_spi_front
  import sfi_pkg::*;
#(
  parameter int         ADDR_W      = 17,
  parameter int         CNT_W       = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MFR_ID      = 8'h62,
  parameter logic [7:0] DEV_ID      = 8'h1D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              si_pin,
  input  logic              hold_n_pin,
  output logic              so,
  output logic              so_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic [7:0]        status_byte,
  output logic              cmd_done,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_aligned,
  output logic [CNT_W-1:0]  cmd_bytes
);
  localparam int HI_W = ADDR_W - 16;

  logic [3:0] pins_s;
  logic cs_s, sck_s, si_s, hold_s;
  logic active, cs_fall, cs_rise, rise_ev, fall_ev, held;
  logic tx_act, tx_end;

  logic [6:0]        sh_in;
  logic [2:0]        bitcnt;
  logic [CNT_W-1:0]  nbytes;
  logic [7:0]        opc;
  logic [ADDR_W-1:0] addr_q, rd_ptr;
  src_e              src;
  logic              id_sel;

  logic [7:0]        bval, tx_load;
  logic              byte_done, st_go, st_id;
  src_e              st_src;
  logic [ADDR_W-1:0] st_addr;

  sfi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n_pin, sck_pin, si_pin, hold_n_pin}), .q(pins_s)
  );
  assign {cs_s, sck_s, si_s, hold_s} = pins_s;

  sfi_events u_evt (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .hold_s(hold_s),
    .active(active), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .held(held)
  );

  assign bval      = {sh_in, si_s};
  assign byte_done = rise_ev && (bitcnt == 3'd7);

  // decide where an answer starts and what feeds it
  always_comb begin
    st_go = 1'b0; st_src = SRC_NONE; st_addr = addr_q; st_id = 1'b0;
    if (byte_done) begin
      if (nbytes == CNT_W'(0)) begin
        if (bval == OP_STAT) begin st_go = 1'b1; st_src = SRC_STAT; end
        else if (bval == OP_JID) begin st_go = 1'b1; st_src = SRC_ID; end
      end else if (nbytes == CNT_W'(3)) begin
        if (opc == OP_READ) begin
          st_go = 1'b1; st_src = SRC_MEM; st_addr = {addr_q[ADDR_W-1:8], bval};
        end else if (opc == OP_RID) begin
          st_go = 1'b1; st_src = SRC_ID; st_id = bval[0];
        end
      end else if (nbytes == CNT_W'(4) && opc == OP_FREAD) begin
        st_go = 1'b1; st_src = SRC_MEM;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_in <= '0; bitcnt <= '0; nbytes <= '0; opc <= '0;
      addr_q <= '0; rd_ptr <= '0; src <= SRC_NONE; id_sel <= 1'b0;
      mem_rd_en <= 1'b0; mem_rd_addr <= '0;
      cmd_done <= 1'b0; cmd_opcode <= '0; cmd_addr <= '0;
      cmd_aligned <= 1'b0; cmd_bytes <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      cmd_done  <= 1'b0;
      if (cs_rise) begin
        cmd_done    <= 1'b1;
        cmd_opcode  <= opc;
        cmd_addr    <= addr_q;
        cmd_aligned <= (bitcnt == 3'd0) && (nbytes != '0);
        cmd_bytes   <= nbytes;
      end
      if (cs_fall || cs_rise) begin
        bitcnt <= '0; nbytes <= '0; opc <= '0; addr_q <= '0; src <= SRC_NONE;
      end
      if (rise_ev) begin
        sh_in  <= bval[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (byte_done) begin
          if (nbytes != '1) nbytes <= nbytes + 1'b1;
          if (nbytes == CNT_W'(0)) opc <= bval;
          if (nbytes == CNT_W'(1)) addr_q[ADDR_W-1:16] <= bval[HI_W-1:0];
          if (nbytes == CNT_W'(2)) addr_q[15:8] <= bval;
          if (nbytes == CNT_W'(3)) addr_q[7:0] <= bval;
        end
      end
      if (st_go) begin
        src    <= st_src;
        id_sel <= st_id;
        if (st_src == SRC_MEM) begin
          mem_rd_en <= 1'b1; mem_rd_addr <= st_addr; rd_ptr <= st_addr;
        end
      end
      if (tx_end && active) begin
        if (src == SRC_MEM) begin
          rd_ptr <= rd_ptr + 1'b1;
          mem_rd_en <= 1'b1;
          mem_rd_addr <= rd_ptr + 1'b1;
        end
        if (src == SRC_ID) id_sel <= !id_sel;
      end
    end
  end

  always_comb begin
    case (src)
      SRC_MEM:  tx_load = mem_rd_data;
      SRC_STAT: tx_load = status_byte;
      SRC_ID:   tx_load = id_sel ? DEV_ID : MFR_ID;
      default:  tx_load = 8'h00;
    endcase
  end

  sfi_tx #(.DW(8)) u_tx (
    .clk(clk), .rst(rst), .clear(cs_fall || cs_rise), .start(st_go),
    .fall_ev(fall_ev), .load(tx_load), .so(so), .act(tx_act), .byte_end(tx_end)
  );

  assign so_oe = tx_act && !held;

  // R3: never drive once chip select has been high for a cycle
  p_quiet_deselect_r3: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !so_oe);
  // R3: driving implies an answer source was chosen
  p_oe_needs_source_r3: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (src != SRC_NONE));
  // R5: no array fetch while deselected
  p_no_fetch_deselected_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !mem_rd_en);
  // R11: the completion report is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);
endmodule

// File: tb/sflash_spi_front_tb_top.sv
module sflash_spi_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4 * CLK_PERIOD;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, mem_rd_en, cmd_done, cmd_aligned;
  logic [16:0] mem_rd_addr, cmd_addr;
  logic [7:0]  mem_rd_data = 8'h00, status_byte = 8'h00, cmd_opcode;
  logic [11:0] cmd_bytes;

  int n_tests = 0, n_fail = 0, r_cnt = 0;
  bit finished = 1'b0, oe_seen;
  logic [7:0] r_op; logic [16:0] r_addr; logic r_al; logic [11:0] r_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_spi_front dut_i (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n), .sck_pin(sck), .si_pin(si),
    .hold_n_pin(hold_n), .so(so), .so_oe(so_oe), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .status_byte(status_byte), .cmd_done(cmd_done), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_aligned(cmd_aligned), .cmd_bytes(cmd_bytes)
  );

  function automatic logic [7:0] mem_f(input logic [16:0] a);
    return a[7:0] ^ {a[15:9], a[16]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_f(mem_rd_addr);

  always @(posedge clk) if (cmd_done) begin
    r_op <= cmd_opcode; r_addr <= cmd_addr; r_al <= cmd_aligned;
    r_bytes <= cmd_bytes; r_cnt <= r_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel(input bit m3);
    sck = m3; #(HALF); cs_n = 1'b0; #(HALF);
    if (m3) sck = 1'b0;
  endtask

  task automatic desel(input bit m3);
    #(HALF); cs_n = 1'b1; #(HALF);
    if (m3) sck = 1'b1;
    #(HALF*3); sck = 1'b0; #(HALF);
    chk("R3 no drive after deselect", so_oe, 0);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = t[i]; #(HALF);
      r[i] = so_oe ? so : 1'bz;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1; #(HALF); sck = 1'b0;
    end
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    xfer(op, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
  endtask

  task automatic hold_seq();
    #(HALF); hold_n = 1'b0; #(HALF*2);
    chk("R10 released output while held", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
    end
    hold_n = 1'b1; #(HALF*2);
    chk("R10 output back after hold", so_oe, 1);
  endtask

  task automatic run_read(input bit m3, input bit fast, input logic [23:0] a,
                          input int n, input bit do_hold, input string tag);
    logic [7:0] r; logic [16:0] p; int c0;
    c0 = r_cnt;
    sel(m3); oe_seen = 1'b0;
    hdr(fast ? 8'h0B : 8'h03, a);
    if (fast) xfer(8'($urandom), r);
    chk({"R3 quiet during input, ", tag}, oe_seen, 0);
    p = a[16:0];
    for (int k = 0; k < n; k++) begin
      if (do_hold && k == 1) hold_seq();
      xfer(8'($urandom), r);
      chk({tag, " data byte"}, r, mem_f(p));
      p = p + 1'b1;
    end
    desel(m3);
    chk("R11 one report per select", r_cnt - c0, 1);
    chk("R11 opcode", r_op, fast ? 8'h0B : 8'h03);
    chk("R11 address", r_addr, a[16:0]);
    chk("R11 byte count", r_bytes, 4 + int'(fast) + n);
    chk("R11 aligned", r_al, 1);
  endtask

  task automatic run_stat(input bit m3, input int n);
    logic [7:0] r;
    status_byte = 8'($urandom);
    sel(m3); oe_seen = 1'b0;
    xfer(8'h05, r);
    chk("R3 quiet during status opcode", oe_seen, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), r);
      chk("R7 status repeat", r, status_byte);
    end
    desel(m3);
    chk("R11 status byte count", r_bytes, 1 + n);
  endtask

  task automatic run_id(input bit m3, input bit rid, input bit a0, input int n);
    logic [7:0] r; bit s;
    sel(m3); oe_seen = 1'b0;
    if (rid) hdr(8'hAB, {8'($urandom), 8'($urandom), 7'($urandom), a0});
    else xfer(8'h9F, r);
    chk("R3 quiet during id request", oe_seen, 0);
    s = rid ? a0 : 1'b0;
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), r);
      chk(rid ? "R9 id byte" : "R8 id byte", r, s ? 8'h1D : 8'h62);
      s = ~s;
    end
    desel(m3);
    chk("R11 id opcode", r_op, rid ? 8'hAB : 8'h9F);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #(HALF);
    chk("R3 reset: output enable", so_oe, 0);
    chk("R11 reset: done", cmd_done, 0);
    chk("R5 reset: no fetch", mem_rd_en, 0);

    run_read(1'b0, 1'b0, 24'h001234, 4, 1'b0, "R4 R2 mode0 read");
    run_read(1'b1, 1'b0, 24'h00ABCD, 3, 1'b0, "R1 mode3 read");
    run_read(1'b0, 1'b0, 24'hFF_FFFE, 4, 1'b0, "R5 wrap");
    run_read(1'b1, 1'b0, 24'hFE_FFFF, 2, 1'b0, "R5 ignored high bits");
    run_read(1'b0, 1'b1, 24'h010203, 3, 1'b0, "R6 fast read");
    run_read(1'b1, 1'b1, 24'h01FFFF, 3, 1'b0, "R6 R1 fast read mode3");
    run_read(1'b0, 1'b0, 24'h004000, 4, 1'b1, "R10 read across hold");
    run_stat(1'b0, 3);
    run_stat(1'b1, 2);
    run_id(1'b0, 1'b0, 1'b0, 4);
    run_id(1'b1, 1'b1, 1'b0, 3);
    run_id(1'b0, 1'b1, 1'b1, 3);

    // R11 partial trailing byte
    sel(1'b0); hdr(8'hD8, 24'h01_8123);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
    end
    desel(1'b0);
    chk("R11 partial opcode", r_op, 8'hD8);
    chk("R11 partial address", r_addr, 17'h18123);
    chk("R11 partial count", r_bytes, 4);
    chk("R11 partial not aligned", r_al, 0);

    // R11 empty selection
    sel(1'b1); desel(1'b1);
    chk("R11 empty opcode", r_op, 8'h00);
    chk("R11 empty count", r_bytes, 0);
    chk("R11 empty not aligned", r_al, 0);

    for (int it = 0; it < 24; it++) begin
      int kind; bit m3;
      kind = int'($urandom % 5); m3 = 1'($urandom);
      case (kind)
        0: run_read(m3, 1'b0, 24'($urandom), 1 + int'($urandom % 5), 1'b0, "R4 random read");
        1: run_read(m3, 1'b1, 24'($urandom), 1 + int'($urandom % 5), 1'b0, "R6 random fast read");
        2: run_stat(m3, 1 + int'($urandom % 3));
        3: run_id(m3, 1'b0, 1'b0, 1 + int'($urandom % 4));
        default: run_id(m3, 1'b1, 1'($urandom), 1 + int'($urandom % 4));
      endcase
    end
    xfer(8'h00, r);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule